// File: doc/BRIEF.md
# SPI Slave Byte Transceiver

This block is the device side of a four-wire serial link, mode 0 timing (clock idles low). It does all of its work in one fast system clock domain. The serial clock, the active-low chip select and the incoming data line are treated as plain data. They pass through a synchroniser, and edges of the serial clock are found by comparing successive samples. No logic is clocked by the serial clock itself.

Each transaction moves one byte in each direction at the same time. When chip select falls, the byte on `tx_byte` is loaded into a transmit shifter. Its top bit appears on `miso_out` before the first clock rise, and the shifter advances on every falling edge. Incoming bits are captured on rising edges, most significant first. The assembled byte is copied to `rx_byte` only when all bits have arrived. `busy` marks the span from the first rising edge to the last falling edge of a frame.

Top module: `spi_byte_slave`

## Requirements
- R1: A synchronous reset drives `rx_byte` to zero, drives `busy` low and drives `miso_out` low.
- R2: At each synchronised rising edge of `sclk_in` while selected, the bit on `mosi_in` is shifted in. The first bit received becomes bit 7 of `rx_byte`.
- R3: `miso_out` shows bit 7 of the loaded byte before the first rising edge. It moves to the next lower bit only on a falling edge of `sclk_in`, so the master sees bits 7 down to 0 in order.
- R4: `tx_byte` is sampled only when `csn_in` falls. Changing it during a frame does not alter the bits sent in that frame.
- R5: `busy` goes high after the first rising edge of a frame and stays high until after the eighth falling edge, where it goes low.
- R6: `rx_byte` changes only when the eighth bit of a frame is captured. A frame ended early by `csn_in` rising leaves `rx_byte` unchanged.
- R7: `csn_in` high clears the bit count, so the frame after an aborted one is received and sent correctly from bit 7.
- R8: Activity on `sclk_in` and `mosi_in` while `csn_in` is high does not change `rx_byte`, and `busy` stays low.
- R9: Clock edges past the eighth in one frame are ignored. `rx_byte` holds the first eight bits and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sclk_in | input | 1 | Serial clock from the master, asynchronous |
| csn_in | input | 1 | Chip select from the master, active low, asynchronous |
| mosi_in | input | 1 | Serial data from the master |
| miso_out | output | 1 | Serial data to the master |
| tx_byte | input | DATA_W | Byte to send in the next frame |
| rx_byte | output | DATA_W | Byte received in the last complete frame |
| busy | output | 1 | High while a frame's bits are moving |

## Verification
The bench goes after frames cut short partway through. A design that committed partial bits would corrupt `rx_byte`. A design that kept its bit count across frames would shift the next frame out of alignment. It also changes `tx_byte` in the middle of a frame, which catches a shifter that reloads late or continuously. It sends extra clock pulses after the eighth bit, which would push `busy` high again or shift garbage into the received byte. It also toggles the clock while chip select is high, where any capture would show up as a spurious `rx_byte` change.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  typedef struct packed {
    logic sck;
    logic csn;
    logic mosi;
  } spi_lines_t;

  // idle levels of the raw pins: clock low, deselected, data low
  localparam spi_lines_t LINES_IDLE = '{sck: 1'b0, csn: 1'b1, mosi: 1'b0};
endpackage

// File: rtl/spi_line_sync.sv
module spi_line_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= INIT;
        else if (s == 0) stage_q[s] <= d_async;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= INIT;
    else prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_lvl,
  input  logic              csn_fall,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_bit,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              miso,
  output logic [DATA_W-1:0] rx_byte,
  output logic              busy,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              frame_done
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] v,
                                                 input logic b);
    return {v[DATA_W-2:0], b};
  endfunction

  logic [DATA_W-1:0] tx_sr, rx_sr;
  logic              capture_ok, advance_ok;

  // a capture is allowed only in an active frame that has room left
  assign capture_ok = !csn_lvl && !csn_fall && sck_rise && (bit_cnt < FULL_CNT);
  assign advance_ok = !csn_lvl && !csn_fall && sck_fall && busy;
  assign frame_done = capture_ok && (bit_cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_byte <= '0;
      bit_cnt <= '0;
      busy    <= 1'b0;
    end else if (csn_lvl) begin
      bit_cnt <= '0;
      busy    <= 1'b0;
    end else if (csn_fall) begin
      tx_sr   <= tx_byte;
      bit_cnt <= '0;
      busy    <= 1'b0;
    end else begin
      if (capture_ok) begin
        rx_sr   <= shift_in(rx_sr, mosi_bit);
        bit_cnt <= bit_cnt + 1'b1;
        busy    <= 1'b1;
        if (frame_done) rx_byte <= shift_in(rx_sr, mosi_bit);
      end
      if (advance_ok) begin
        tx_sr <= shift_in(tx_sr, 1'b0);
        if (bit_cnt == FULL_CNT) busy <= 1'b0;
      end
    end
  end

  assign miso = tx_sr[DATA_W-1];
endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave
  import spi_slv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_in,
  input  logic              csn_in,
  input  logic              mosi_in,
  output logic              miso_out,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              busy
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  spi_lines_t lines_raw, lines_s;
  logic       sck_rise, sck_fall, csn_rise_unused, csn_fall;
  logic [CNT_W-1:0] bit_cnt;
  logic       frame_done;

  assign lines_raw = '{sck: sclk_in, csn: csn_in, mosi: mosi_in};

  spi_line_sync #(.WIDTH($bits(spi_lines_t)), .STAGES(SYNC_STAGES), .INIT(LINES_IDLE))
    u_sync (.clk(clk), .rst(rst), .d_async(lines_raw), .q_sync(lines_s));

  spi_edge_det #(.INIT(1'b0))
    u_sck_edge (.clk(clk), .rst(rst), .lvl(lines_s.sck), .rise(sck_rise), .fall(sck_fall));

  spi_edge_det #(.INIT(1'b1))
    u_csn_edge (.clk(clk), .rst(rst), .lvl(lines_s.csn), .rise(csn_rise_unused), .fall(csn_fall));

  spi_shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst),
    .csn_lvl(lines_s.csn), .csn_fall(csn_fall),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .mosi_bit(lines_s.mosi), .tx_byte(tx_byte),
    .miso(miso_out), .rx_byte(rx_byte), .busy(busy),
    .bit_cnt(bit_cnt), .frame_done(frame_done)
  );
endmodule

// File: rtl/spi_byte_slave_chk.sv
module spi_byte_slave_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              csn_s,
  input logic              csn_fall,
  input logic              sck_rise,
  input logic              sck_fall,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              frame_done,
  input logic              miso_out,
  input logic [DATA_W-1:0] tx_byte,
  input logic [DATA_W-1:0] rx_byte,
  input logic              busy
);
  assert_busy_idle_R8: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !busy);

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(DATA_W));

  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> $stable(rx_byte));

  assert_load_msb_R4: assert property (@(posedge clk) disable iff (rst)
    csn_fall |=> (miso_out == $past(tx_byte[DATA_W-1])));

  assert_busy_start_R5: assert property (@(posedge clk) disable iff (rst)
    (sck_rise && !csn_s && !csn_fall && bit_cnt == '0) |=> busy);

  assert_miso_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!sck_fall && !csn_fall) |=> $stable(miso_out));
endmodule

bind spi_byte_slave spi_byte_slave_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .csn_s(lines_s.csn), .csn_fall(csn_fall),
  .sck_rise(sck_rise), .sck_fall(sck_fall), .bit_cnt(bit_cnt),
  .frame_done(frame_done), .miso_out(miso_out), .tx_byte(tx_byte),
  .rx_byte(rx_byte), .busy(busy)
);

// File: tb/tb_spi_byte_slave.sv
module tb_spi_byte_slave;
  localparam int HALF = 6;   // system clocks per serial half-period

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso;
  logic [7:0] tx_byte = 8'h00;
  logic [7:0] rx_byte;
  logic busy;

  int checks = 0, failures = 0;
  logic [7:0] exp_rx = 8'h00;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_byte_slave dut (
    .clk(clk), .rst(rst), .sclk_in(sclk), .csn_in(csn), .mosi_in(mosi),
    .miso_out(miso), .tx_byte(tx_byte), .rx_byte(rx_byte), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected received byte: first eight bits of the master's stream, MSB first
  function automatic logic [7:0] first_byte(input logic [15:0] stream, input int nbits);
    return stream[15:8];
  endfunction

  task automatic frame(input logic [7:0] tx, input logic [15:0] stream, input int nbits,
                       input bit change_tx);
    logic [7:0] seen;
    bit busy_mid_ok;
    seen = 8'h00;
    busy_mid_ok = 1'b1;
    tx_byte = tx;
    wclk(1);
    csn = 1'b0;
    wclk(HALF + 2);
    chk(miso == tx[7], "R3 msb before first rise", {7'd0, miso}, {7'd0, tx[7]});
    if (change_tx) tx_byte = ~tx;
    for (int i = 0; i < nbits; i++) begin
      mosi = stream[15-i];
      wclk(HALF);
      if (i < 8) seen = {seen[6:0], miso};
      sclk = 1'b1;
      wclk(HALF);
      if (i < 8 && !busy) busy_mid_ok = 1'b0;
      sclk = 1'b0;
    end
    wclk(HALF);
    if (nbits >= 8) begin
      chk(seen == tx, change_tx ? "R4 tx held for frame" : "R3 miso order", seen, tx);
      chk(busy_mid_ok, "R5 busy high during bits", {7'd0, busy_mid_ok}, 8'h01);
      chk(busy == 1'b0, nbits > 8 ? "R9 busy low after extra edges" : "R5 busy low after last fall",
          {7'd0, busy}, 8'h00);
      exp_rx = first_byte(stream, nbits);
    end
    csn = 1'b1;
    wclk(HALF + 4);
    if (nbits > 8)
      chk(rx_byte == exp_rx, "R9 first eight bits kept", rx_byte, exp_rx);
    else if (nbits == 8)
      chk(rx_byte == exp_rx, "R2 received byte", rx_byte, exp_rx);
    else
      chk(rx_byte == exp_rx, "R6 abort keeps rx", rx_byte, exp_rx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=00 expected=01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE11));
    wclk(4);
    chk(rx_byte == 8'h00, "R1 rx after reset", rx_byte, 8'h00);
    chk(busy == 1'b0, "R1 busy after reset", {7'd0, busy}, 8'h00);
    chk(miso == 1'b0, "R1 miso after reset", {7'd0, miso}, 8'h00);
    rst = 1'b0;
    wclk(6);

    frame(8'hA5, {8'h3C, 8'h00}, 8, 0);       // R2 R3 R5
    frame(8'h81, {8'hFF, 8'h00}, 8, 0);
    frame(8'h7E, {8'h00, 8'h00}, 8, 0);
    frame(8'h5A, {8'hC3, 8'h00}, 8, 1);       // R4: tx changed mid frame
    frame(8'h12, {8'h99, 8'h00}, 5, 0);       // R6 abort
    frame(8'hE7, {8'h4B, 8'h00}, 8, 0);       // R7 fresh frame after abort
    chk(rx_byte == 8'h4B, "R7 frame after abort", rx_byte, 8'h4B);
    frame(8'h0F, {8'h1D, 8'hFF}, 11, 0);      // R9 extra edges

    // R8: clock and data toggling while deselected
    for (int i = 0; i < 6; i++) begin
      mosi = i[0];
      sclk = 1'b1; wclk(HALF);
      chk(busy == 1'b0, "R8 busy while deselected", {7'd0, busy}, 8'h00);
      sclk = 1'b0; wclk(HALF);
    end
    wclk(4);
    chk(rx_byte == exp_rx, "R8 rx unchanged while deselected", rx_byte, exp_rx);

    for (int k = 0; k < 20; k++) begin
      logic [7:0] t, m;
      int n;
      t = 8'($urandom);
      m = 8'($urandom);
      n = ($urandom % 4 == 0) ? int'($urandom % 7) + 1 : 8;
      frame(t, {m, 8'($urandom)}, n, bit'($urandom % 2));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule